// File: doc/BRIEF.md
# Directed Rounding Result Fixup

This block takes a floating-point result that an upstream datapath has already rounded toward zero and turns it into the result for round toward positive infinity or round toward negative infinity. It does not round again. It adds one to the packed bit pattern of each lane whose sign points away from the requested direction. This works because, for IEEE-754 encodings, the next larger magnitude is exactly the next integer bit pattern.

The block always sees a 64-bit register pair, which it treats in one of three ways:

- **Single:** one single-precision value in the low word.
- **Double:** one double-precision value across all 64 bits.
- **Paired:** two single-precision lanes, one per word.

A compare flag forces pass-through, because compare results are not numbers. A per-lane inexact indication gates the correction, so that exact results are never nudged. The corrected value is registered and appears with a valid strobe one cycle after the input is accepted.

Top module: `dir_round_fix`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `out_data` is all zeros until the first accepted input.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. When `in_valid` is low, `out_data` keeps its previous value.
- R3: For rounding field `rmode` 00 (nearest) or 01 (toward zero), `out_data` equals the accepted `in_data`.
- R4: When `is_compare` is 1, `out_data` equals `in_data`, whatever the mode.
- R5: A lane whose inexact bit is 0 is never changed. `inexact[0]` covers the low word and double values; `inexact[1]` covers the high word in paired format.
- R6: With `rmode` 10 (toward +Inf), an inexact lane with sign bit 0 is incremented by one, and a lane with sign bit 1 is left unchanged.
- R7: With `rmode` 11 (toward -Inf), an inexact lane with sign bit 1 is incremented by one, and a lane with sign bit 0 is left unchanged.
- R8: In single format (`fmt` 00), the lane is bits 31:0 with its sign at bit 31, and bits 63:32 pass through unchanged.
- R9: In double format (`fmt` 01), the sign is bit 63 and the increment applies to all 64 bits, so a carry from the low word enters the high word.
- R10: In paired format (`fmt` 10), the low word (sign bit 31) and the high word (sign bit 63) are corrected independently. A low word of all ones wraps to zero with no carry into the high word.
- R11: `fmt` 11 is reserved and passes `in_data` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 64 | Truncated result, as a register pair |
| fmt | input | 2 | 00 single, 01 double, 10 paired, 11 reserved |
| rmode | input | 2 | 00 nearest, 01 zero, 10 +Inf, 11 -Inf |
| inexact | input | 2 | Per-lane inexact indication (bit 0 low/double, bit 1 high) |
| is_compare | input | 1 | Result comes from a compare; suppresses correction |
| out_valid | output | 1 | Corrected result valid |
| out_data | output | 64 | Corrected result |

## Verification
Carry propagation is the hardest behaviour to reach from the ports: it needs a low word of exactly all ones combined with a positive-direction mode and a set inexact bit. Random data almost never produces that pattern. The stimulus therefore forces all-ones and near-all-ones low words in directed cases, in every format. This shows that double format carries into the high word while paired format wraps within its lane. Random cases then mix every format, mode, sign and inexact combination with the compare flag.

// File: rtl/dir_round_fix.sv
module dir_round_fix #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic [1:0]   fmt,
  input  logic [1:0]   rmode,
  input  logic [1:0]   inexact,
  input  logic         is_compare,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int H = W / 2;
  localparam logic [1:0] F_SGL = 2'b00;
  localparam logic [1:0] F_DBL = 2'b01;
  localparam logic [1:0] F_PAIR = 2'b10;

  logic directed;
  logic bump_lo, bump_hi, bump_dbl;
  logic [W-1:0] fixed;

  assign directed = rmode[1] & ~is_compare;
  assign bump_lo  = directed & inexact[0] & (in_data[H-1] == rmode[0]);
  assign bump_hi  = directed & inexact[1] & (in_data[W-1] == rmode[0]);
  assign bump_dbl = directed & inexact[0] & (in_data[W-1] == rmode[0]);

  always_comb begin
    fixed = in_data;
    case (fmt)
      F_SGL:  fixed[H-1:0] = in_data[H-1:0] + H'(bump_lo);
      F_DBL:  fixed = in_data + W'(bump_dbl);
      F_PAIR: begin
        fixed[H-1:0] = in_data[H-1:0] + H'(bump_lo);
        fixed[W-1:H] = in_data[W-1:H] + H'(bump_hi);
      end
      default: fixed = in_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= fixed;
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));
  p_nodir_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rmode[1]) |=> out_data == $past(in_data));
  p_cmp_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_compare) |=> out_data == $past(in_data));
  p_sgl_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == F_SGL) |=> out_data[W-1:H] == $past(in_data[W-1:H]));
  p_pair_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == F_PAIR) |=>
      ((out_data[H-1:0] - $past(in_data[H-1:0])) <= H'(1)) &&
      ((out_data[W-1:H] - $past(in_data[W-1:H])) <= H'(1)));
  p_rsvd_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b11) |=> out_data == $past(in_data));
endmodule

// File: tb/dir_round_fix_test.sv
module dir_round_fix_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [63:0] in_data = '0;
  logic [1:0]  fmt = '0, rmode = '0, inexact = '0;
  logic        is_compare = 0;
  logic        out_valid;
  logic [63:0] out_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dir_round_fix uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .fmt(fmt), .rmode(rmode), .inexact(inexact), .is_compare(is_compare),
    .out_valid(out_valid), .out_data(out_data));

  function automatic logic [31:0] lane_up(logic [31:0] v, logic [1:0] rm, logic ix);
    if (!ix) return v;
    if (rm == 2'b10 && !v[31]) return v + 1;
    if (rm == 2'b11 && v[31]) return v + 1;
    return v;
  endfunction

  function automatic logic [63:0] model(logic [63:0] d, logic [1:0] f, logic [1:0] rm,
                                        logic [1:0] ix, logic cmp);
    logic [63:0] r = d;
    if (cmp || !rm[1]) return d;
    case (f)
      2'b00: r[31:0] = lane_up(d[31:0], rm, ix[0]);
      2'b01: if (ix[0] && ((rm == 2'b10 && !d[63]) || (rm == 2'b11 && d[63]))) r = d + 1;
      2'b10: begin
        r[31:0]  = lane_up(d[31:0], rm, ix[0]);
        r[63:32] = lane_up(d[63:32], rm, ix[1]);
      end
      default: r = d;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [63:0] d, logic [1:0] f, logic [1:0] rm,
                       logic [1:0] ix, logic cmp);
    @(negedge clk);
    in_valid = 1; in_data = d; fmt = f; rmode = rm; inexact = ix; is_compare = cmp;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check(req, out_data, model(d, f, rm, ix, cmp));
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset data", out_data, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", out_data, 64'd0);

    apply("R6 single +Inf pos", 64'h1111_1111_3F80_0000, 2'b00, 2'b10, 2'b01, 0);
    check("R6 single +Inf pos value", out_data, 64'h1111_1111_3F80_0001);
    apply("R6 single +Inf neg", 64'h1111_1111_BF80_0000, 2'b00, 2'b10, 2'b01, 0);
    apply("R7 single -Inf neg", 64'h2222_2222_BF80_0000, 2'b00, 2'b11, 2'b01, 0);
    check("R7 single -Inf neg value", out_data, 64'h2222_2222_BF80_0001);
    apply("R7 single -Inf pos", 64'h2222_2222_3F80_0000, 2'b00, 2'b11, 2'b01, 0);
    apply("R8 single high kept", 64'h7FFF_FFFF_7FFF_FFFF, 2'b00, 2'b10, 2'b11, 0);
    check("R8 single high value", out_data, 64'h7FFF_FFFF_8000_0000);
    apply("R9 double carry", 64'h3FF0_0000_FFFF_FFFF, 2'b01, 2'b10, 2'b01, 0);
    check("R9 double carry value", out_data, 64'h3FF0_0001_0000_0000);
    apply("R9 double -Inf neg", 64'hBFF0_0000_FFFF_FFFF, 2'b01, 2'b11, 2'b01, 0);
    apply("R9 double sign from bit63", 64'h3FF0_0000_8000_0000, 2'b01, 2'b11, 2'b01, 0);
    apply("R10 paired wrap", 64'h0000_0001_FFFF_FFFF, 2'b10, 2'b11, 2'b11, 0);
    check("R10 paired wrap value", out_data, 64'h0000_0001_0000_0000);
    apply("R10 paired split", 64'h4000_0000_C000_0000, 2'b10, 2'b10, 2'b11, 0);
    check("R10 paired split value", out_data, 64'h4000_0001_C000_0000);
    apply("R5 paired high exact", 64'h4000_0000_4000_0000, 2'b10, 2'b10, 2'b01, 0);
    check("R5 paired high exact value", out_data, 64'h4000_0000_4000_0001);
    apply("R5 double exact", 64'h3FF0_0000_FFFF_FFFF, 2'b01, 2'b10, 2'b00, 0);
    apply("R3 nearest pass", 64'h3FF0_0000_FFFF_FFFF, 2'b01, 2'b00, 2'b11, 0);
    apply("R3 zero pass", 64'h0000_0000_3F80_0000, 2'b10, 2'b01, 2'b11, 0);
    apply("R4 compare pass", 64'h0000_0000_3F80_0000, 2'b10, 2'b10, 2'b11, 1);
    check("R4 compare value", out_data, 64'h0000_0000_3F80_0000);
    apply("R11 reserved pass", 64'h0000_0000_3F80_0000, 2'b11, 2'b10, 2'b11, 0);

    held = out_data;
    @(negedge clk);
    in_data = 64'hDEAD_BEEF_0000_0000;
    @(negedge clk);
    check("R2 idle valid low", {63'd0, out_valid}, 64'd0);
    check("R2 idle hold", out_data, held);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      if (i % 5 == 0) d[31:0] = 32'hFFFF_FFFF;
      if (i % 7 == 0) d[31:0] = 32'h7FFF_FFFF;
      apply("R5-R11 random", d, 2'($urandom), 2'($urandom), 2'($urandom),
            ($urandom % 6) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule